// File: doc/BRIEF.md
# Two-Level Constant-Weight Symbol Encoder for Three Four-Wire Channels

This block turns a 6-bit binary word into three 4-bit symbols. Each symbol has exactly two bits set, so every one of the three four-wire channels always carries a balanced code. The encoding works on two levels.

At the upper level, the three most significant data bits are read as a number from 0 to 7 and rewritten as two base-3 digits. A third base-3 digit is added as a checksum, so that the three digits sum to zero modulo 3. Each digit names one of three pairs of weight-2 symbols, and within each pair the two symbols are bit complements of each other. At the lower level, each of the three least significant data bits picks one of the two members of the pair for its channel. The checksum channel therefore still carries one data bit.

A receiver can use the known pair of a channel to correct a single flipped wire in that channel. The encoder is pipelined. A register sits between the digit stage and the symbol stage, and a second register sits at the output.

Top module: `cw_pair_encoder`

## Requirements
- R1: Whenever `out_valid` is 1, each 4-bit channel field of `out_sym` has exactly two bits set.
- R2: Let `in_data[5:3]` be the value v, from 0 to 7. Channel 0 (`out_sym[3:0]`) uses pair floor(v/3), and channel 1 (`out_sym[7:4]`) uses pair v mod 3.
- R3: Channel 2 (`out_sym[11:8]`) uses the pair whose index makes the three pair indices sum to 0 mod 3.
- R4: There are three pairs. Pair 0 is {0011, 1100}, pair 1 is {0101, 1010} and pair 2 is {0110, 1001}. Channel i takes its selector bit from `in_data[2-i]`. A selector of 0 gives the first member of the pair and a selector of 1 gives the second member, which is its bitwise complement.
- R5: A word accepted with `in_valid`=1 appears at the outputs with `out_valid`=1 exactly two clock cycles later. `out_valid` is 0 in every cycle that does not correspond to an accepted word.
- R6: While `rst_n` is low, and right after it is released, `out_valid` is 0 and `out_sym` is all zeros.
- R7: Cycles with `in_valid`=0 leave `out_sym` unchanged, whatever the value of `in_data`.
- R8: Channels 0 and 1 never both use pair 2.
- R9: A new word can be accepted in every cycle. Back-to-back words come out in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks `in_data` as a word to encode |
| in_data | input | 6 | Bits 5:3 select the pairs, bits 2:0 select members |
| out_valid | output | 1 | Marks `out_sym` as a newly encoded word |
| out_sym | output | 12 | Channel i symbol on bits [4i+3:4i] |

## Verification
The bench streams all 64 input words back to back. It checks every channel symbol against a table built inside the bench. A design that swapped the digit order, or took a selector bit from the wrong end of the word, would put the wrong pair on channels 0 and 1 even though every symbol still had two bits set. The bench recovers the pair index from each output and checks the modulo-3 sum and the absence of the (2,2) digit pair. A checksum that was off by one, or wrapped wrongly at a sum of 3, therefore fails on some value. Separate scenarios check the exact two-cycle timing of a single word, and confirm that idle cycles with changing data leave the symbols frozen. A design that loaded its registers without an enable would fail those checks.

// File: rtl/cw_pair_pkg.sv
package cw_pair_pkg;
    localparam int CH_NUM  = 3;
    localparam int SYM_W   = 4;
    localparam int SEL_W   = 3;
    localparam int MEM_W   = CH_NUM;
    localparam int DATA_W  = SEL_W + MEM_W;
    localparam int TRIT_W  = 2;
    localparam int OUT_W   = CH_NUM * SYM_W;

    typedef logic [TRIT_W-1:0] trit_t;

    typedef struct packed {
        logic                     valid;
        logic [CH_NUM-1:0][TRIT_W-1:0] trit;
        logic [CH_NUM-1:0]        msel;
    } lvl_t;

    typedef struct packed {
        logic                      valid;
        logic [CH_NUM-1:0][SYM_W-1:0] sym;
    } sym_reg_t;

    function automatic logic [SYM_W-1:0] pair_base(input trit_t t);
        case (t)
            2'd0:    pair_base = 4'b0011;
            2'd1:    pair_base = 4'b0101;
            2'd2:    pair_base = 4'b0110;
            default: pair_base = 4'b0000;
        endcase
    endfunction
endpackage

// File: rtl/cw_pair_digit_stage.sv
module cw_pair_digit_stage
    import cw_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output lvl_t              lvl_o
);
    lvl_t lvl_d, lvl_q;

    logic [SEL_W-1:0] sel_val;
    logic [SEL_W-1:0] rem_val;
    trit_t            hi_t, lo_t, chk_t;
    logic [2:0]       sum_t, mod_t;

    always_comb begin
        sel_val = in_data[DATA_W-1 -: SEL_W];
        if (sel_val >= SEL_W'(6)) begin
            hi_t    = 2'd2;
            rem_val = sel_val - SEL_W'(6);
        end else if (sel_val >= SEL_W'(3)) begin
            hi_t    = 2'd1;
            rem_val = sel_val - SEL_W'(3);
        end else begin
            hi_t    = 2'd0;
            rem_val = sel_val;
        end
        lo_t  = rem_val[TRIT_W-1:0];
        sum_t = {1'b0, hi_t} + {1'b0, lo_t};
        mod_t = (sum_t >= 3'd3) ? sum_t - 3'd3 : sum_t;
        chk_t = (mod_t[1:0] == 2'd0) ? 2'd0 : 2'd3 - mod_t[1:0];

        lvl_d       = lvl_q;
        lvl_d.valid = in_valid;
        if (in_valid) begin
            lvl_d.trit[0]        = hi_t;
            lvl_d.trit[1]        = lo_t;
            lvl_d.trit[CH_NUM-1] = chk_t;
            for (int i = 0; i < CH_NUM; i++) begin
                lvl_d.msel[i] = in_data[MEM_W-1-i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign lvl_o = lvl_q;

    assert_checksum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q.valid |-> ((int'(lvl_q.trit[0]) + int'(lvl_q.trit[1]) + int'(lvl_q.trit[2])) % 3 == 0));

    assert_no_pair22_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q.valid |-> !(lvl_q.trit[0] == 2'd2 && lvl_q.trit[1] == 2'd2));

    assert_digit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q.valid |-> (lvl_q.trit[0] != 2'd3 && lvl_q.trit[1] != 2'd3 && lvl_q.trit[2] != 2'd3));

    assert_stage1_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (lvl_q.valid == $past(in_valid)));
endmodule

// File: rtl/cw_pair_sym_lut.sv
module cw_pair_sym_lut
    import cw_pair_pkg::*;
(
    input  trit_t            trit_i,
    input  logic             msel_i,
    output logic [SYM_W-1:0] sym_o
);
    logic [SYM_W-1:0] base;

    always_comb begin
        base  = pair_base(trit_i);
        sym_o = msel_i ? ~base : base;
        if (trit_i == 2'd3) sym_o = '0;
    end
endmodule

// File: rtl/cw_pair_out_stage.sv
module cw_pair_out_stage
    import cw_pair_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [CH_NUM-1:0][SYM_W-1:0]  sym_i,
    output sym_reg_t                      out_o
);
    sym_reg_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) out_d.sym = sym_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_o = out_q;

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(out_q.sym));

    assert_stage2_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_q.valid == $past(in_valid)));
endmodule

// File: rtl/cw_pair_encoder.sv
module cw_pair_encoder
    import cw_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_sym
);
    lvl_t                         lvl;
    logic [CH_NUM-1:0][SYM_W-1:0] sym_c;
    sym_reg_t                     out_r;

    cw_pair_digit_stage u_digit (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .lvl_o    (lvl)
    );

    for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
        cw_pair_sym_lut u_lut (
            .trit_i (lvl.trit[g]),
            .msel_i (lvl.msel[g]),
            .sym_o  (sym_c[g])
        );

        assert_weight_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ($countones(out_sym[g*SYM_W +: SYM_W]) == 2));
    end

    cw_pair_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (lvl.valid),
        .sym_i    (sym_c),
        .out_o    (out_r)
    );

    assign out_valid = out_r.valid;
    assign out_sym   = out_r.sym;
endmodule

// File: tb/cw_pair_encoder_tb.sv
module cw_pair_encoder_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  in_data = '0;
    logic        out_valid;
    logic [11:0] out_sym;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cw_pair_encoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sym   (out_sym)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] member(input int pair, input bit sel);
        logic [3:0] s;
        case (pair)
            0: s = sel ? 4'b1100 : 4'b0011;
            1: s = sel ? 4'b1010 : 4'b0101;
            default: s = sel ? 4'b1001 : 4'b0110;
        endcase
        return s;
    endfunction

    function automatic int pair_of(input logic [3:0] s);
        case (s)
            4'b0011, 4'b1100: return 0;
            4'b0101, 4'b1010: return 1;
            4'b0110, 4'b1001: return 2;
            default:          return 9;
        endcase
    endfunction

    function automatic logic [11:0] expect_word(input logic [5:0] w);
        int v = int'(w[5:3]);
        int p0 = v / 3;
        int p1 = v % 3;
        int p2 = (3 - ((p0 + p1) % 3)) % 3;
        return {member(p2, w[0]), member(p1, w[1]), member(p0, w[2])};
    endfunction

    task automatic t_reset();
        check(out_valid == 1'b0, "R6 valid in reset", 32'(out_valid), 0);
        check(out_sym == 12'h000, "R6 symbols in reset", 32'(out_sym), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R6 valid after release", 32'(out_valid), 0);
        check(out_sym == 12'h000, "R6 symbols after release", 32'(out_sym), 0);
    endtask

    task automatic t_example();
        in_valid = 1'b1; in_data = 6'b111101;
        @(negedge clk); in_valid = 1'b0; in_data = '0;
        @(negedge clk);
        check(out_valid == 1'b1, "R5 example valid", 32'(out_valid), 1);
        check(out_sym[3:0] == 4'b1001, "R2 R4 channel 0", 32'(out_sym[3:0]), 32'h9);
        check(out_sym[7:4] == 4'b0101, "R2 R4 channel 1", 32'(out_sym[7:4]), 32'h5);
        check(out_sym[11:8] == 4'b1100, "R3 R4 checksum channel", 32'(out_sym[11:8]), 32'hC);
        @(negedge clk);
    endtask

    task automatic t_latency();
        in_valid = 1'b1; in_data = 6'b011010;
        @(negedge clk); in_valid = 1'b0;
        check(out_valid == 1'b0, "R5 not valid after one cycle", 32'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R5 valid after two cycles", 32'(out_valid), 1);
        check(out_sym == expect_word(6'b011010), "R5 data after two cycles", 32'(out_sym), 32'(expect_word(6'b011010)));
        @(negedge clk);
        check(out_valid == 1'b0, "R5 valid drops", 32'(out_valid), 0);
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 66; k++) begin
            if (k >= 2) begin
                logic [11:0] e = expect_word(6'(k - 2));
                int sum = 0;
                check(out_valid == 1'b1, "R9 streaming valid", 32'(out_valid), 1);
                check(out_sym == e, "R2 R4 R9 sweep symbols", 32'(out_sym), 32'(e));
                for (int c = 0; c < 3; c++) begin
                    check($countones(out_sym[c*4 +: 4]) == 2, "R1 weight", 32'(out_sym[c*4 +: 4]), 2);
                    sum += pair_of(out_sym[c*4 +: 4]);
                end
                check(sum % 3 == 0, "R3 pair sum mod 3", 32'(sum), 0);
                check(!(pair_of(out_sym[3:0]) == 2 && pair_of(out_sym[7:4]) == 2), "R8 no pair 2,2",
                      32'(out_sym[7:0]), 0);
            end
            if (k < 64) begin in_valid = 1'b1; in_data = 6'(k); end
            else        begin in_valid = 1'b0; in_data = '0; end
            @(negedge clk);
        end
    endtask

    task automatic t_hold();
        logic [11:0] kept;
        in_valid = 1'b1; in_data = 6'b100011;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        kept = out_sym;
        check(kept == expect_word(6'b100011), "R7 loaded word", 32'(kept), 32'(expect_word(6'b100011)));
        for (int i = 0; i < 5; i++) begin
            in_data = 6'(7 * i + 5);
            @(negedge clk);
            check(out_sym == kept, "R7 idle hold", 32'(out_sym), 32'(kept));
            check(out_valid == 1'b0, "R7 R5 idle valid low", 32'(out_valid), 0);
        end
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_example();
                t_latency();
                t_sweep();
                t_hold();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule